// File: doc/BRIEF.md
# Bidirectional Column Scan Register

This block models the scan logic of a display column driver. The columns are split into groups of twelve adjacent columns, and one group is strobed per scan step, so twelve video inputs are sampled at once. A start pulse is loaded into a one-hot token chain, and the token moves by one group on every rising edge of either phase of a two-phase scan clock. The phases are complementary and each has a 50% duty cycle. The phase lines are sampled in the system clock domain, and edges are found by comparing each line with its value one clock earlier.

A direction input selects an ascending (right) or descending (left) scan, and the left order is the exact mirror of the right order. A width-select input picks the full width of 1032 columns (86 groups, which includes four border columns on each side of the 1024 active columns) or the narrow 5:4 width of 960 columns (80 groups). In the narrow mode, three groups on each side lie outside the active area. The token never enters these groups, and their black-force flags are raised so that the picture stays centred. Direction and width are latched when a line starts and are held for the rest of that line.

Top module: `col_scan_top`

## Requirements
- R1: After reset, every group enable and every black-force flag is 0.
- R2: When the system clock sees phase 1 rise while start is high, the following cycle shows exactly one enable. It is on group 0 for right/full, group 85 for left/full, group 3 for right/narrow and group 82 for left/narrow. Start is ignored on a phase 2 rise and at any time when no phase edge occurs.
- R3: No more than one group enable is high in any cycle.
- R4: Each step moves the token by one group. Right scan (dir_right=1) counts the group index up and left scan (dir_right=0) counts it down. In the same mode, the left scan at step k is on group 85 minus the group the right scan is on at step k.
- R5: In full mode (wide_n=1), a line lasts 86 steps. On the 87th step all enables go to 0.
- R6: In narrow mode (wide_n=0), a line lasts 80 steps. On the 81st step all enables go to 0.
- R7: In narrow mode, the black-force flags of groups 0 to 2 and 83 to 85 are 1 and all other flags are 0. In full mode all flags are 0. A group whose black flag is set is never enabled.
- R8: Changes to dir_right or wide_n during a line have no effect on the enable sequence or on the black flags until the next start.
- R9: The enables change only in the cycle after a phase rising edge.
- R10: A start during a running line drops the old token and begins again from the first group, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase1 | input | 1 | Scan clock phase 1; a start is taken only on its rising edge |
| phase2 | input | 1 | Scan clock phase 2, complement of phase 1 |
| start | input | 1 | Line start pulse |
| dir_right | input | 1 | 1: ascending scan, 0: descending scan |
| wide_n | input | 1 | 1: full width (86 groups), 0: narrow 5:4 width (80 groups) |
| grp_en | output | 86 | One-hot sample enable, one bit per group of 12 columns |
| grp_black | output | 86 | Black-force flag, one bit per group |

## Verification
A restart and a token shift can happen in the same cycle. The load of a new first group then has to win over the advance of the old token. The bench provokes this by raising start on a phase 1 edge deep inside a running line. It checks that the following cycle shows exactly one enable, on the first group of the new configuration. A second overlap is a change of direction or width that lands on the same edge as a normal shift. In that case the latched configuration of the line must still decide the move. The bench compares every step of all four direction and width combinations against an index computed arithmetically from the step number.

// File: rtl/col_scan_pkg.sv
package col_scan_pkg;

  // Line configuration, latched when a line starts
  typedef struct packed {
    logic right;  // 1: ascending group index
    logic wide;   // 1: full width, 0: narrow centred width
  } scan_cfg_t;

  localparam scan_cfg_t CFG_RESET = '{right: 1'b1, wide: 1'b1};

endpackage

// File: rtl/cs_phase_edge.sv
module cs_phase_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic phase1,
  input  logic phase2,
  output logic rise1,
  output logic step
);
  logic p1_q, p2_q;

  // Reset to 1 so that a level already high at reset release is no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q <= 1'b1;
      p2_q <= 1'b1;
    end else begin
      p1_q <= phase1;
      p2_q <= phase2;
    end
  end

  assign rise1 = phase1 & ~p1_q;
  assign step  = rise1 | (phase2 & ~p2_q);
endmodule

// File: rtl/cs_line_cfg.sv
module cs_line_cfg
  import col_scan_pkg::*;
#(
  parameter int NUM_GROUPS    = 86,
  parameter int BORDER_GROUPS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  dir_in,
  input  logic                  wide_in,
  output scan_cfg_t             eff_cfg,
  output logic [NUM_GROUPS-1:0] black_o
);
  scan_cfg_t cur_q;
  logic [NUM_GROUPS-1:0] border_mask;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_mask
      localparam bit IS_BORDER = (g < BORDER_GROUPS) || (g >= NUM_GROUPS - BORDER_GROUPS);
      assign border_mask[g] = IS_BORDER;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= CFG_RESET;
      black_o <= '0;
    end else if (load) begin
      cur_q   <= '{right: dir_in, wide: wide_in};
      black_o <= wide_in ? '0 : border_mask;
    end
  end

  // A new line uses the incoming pins; a running line uses the latched copy
  always_comb begin
    if (load) eff_cfg = '{right: dir_in, wide: wide_in};
    else      eff_cfg = cur_q;
  end
endmodule

// File: rtl/cs_token_chain.sv
module cs_token_chain
  import col_scan_pkg::*;
#(
  parameter int NUM_GROUPS    = 86,
  parameter int BORDER_GROUPS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  step,
  input  scan_cfg_t             cfg,
  output logic [NUM_GROUPS-1:0] tok
);
  localparam int LAST   = NUM_GROUPS - 1;
  localparam int LO_NAR = BORDER_GROUPS;
  localparam int HI_NAR = NUM_GROUPS - 1 - BORDER_GROUPS;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_stage
      localparam bit IS_BORDER = (g < BORDER_GROUPS) || (g > HI_NAR);
      localparam bit FIRST_RF  = (g == 0);
      localparam bit FIRST_LF  = (g == LAST);
      localparam bit FIRST_RN  = (g == LO_NAR);
      localparam bit FIRST_LN  = (g == HI_NAR);

      logic from_lower, from_upper, allowed, is_first, nxt;

      if (g == 0) begin : g_lo_edge
        assign from_lower = 1'b0;
      end else begin : g_lo_mid
        assign from_lower = tok[g-1];
      end

      if (g == LAST) begin : g_hi_edge
        assign from_upper = 1'b0;
      end else begin : g_hi_mid
        assign from_upper = tok[g+1];
      end

      assign allowed  = cfg.wide | ~IS_BORDER;
      assign is_first = cfg.right ? (cfg.wide ? FIRST_RF : FIRST_RN)
                                  : (cfg.wide ? FIRST_LF : FIRST_LN);

      always_comb begin
        if (load)      nxt = is_first;
        else if (step) nxt = allowed & (cfg.right ? from_lower : from_upper);
        else           nxt = tok[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tok[g] <= 1'b0;
        else        tok[g] <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/col_scan_top.sv
module col_scan_top
  import col_scan_pkg::*;
#(
  parameter int TOTAL_COLS     = 1032,
  parameter int NARROW_COLS    = 960,
  parameter int COLS_PER_GROUP = 12
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   phase1,
  input  logic                                   phase2,
  input  logic                                   start,
  input  logic                                   dir_right,
  input  logic                                   wide_n,
  output logic [TOTAL_COLS/COLS_PER_GROUP-1:0]   grp_en,
  output logic [TOTAL_COLS/COLS_PER_GROUP-1:0]   grp_black
);
  localparam int NUM_GROUPS    = TOTAL_COLS / COLS_PER_GROUP;
  localparam int NARROW_GROUPS = NARROW_COLS / COLS_PER_GROUP;
  localparam int BORDER_GROUPS = (NUM_GROUPS - NARROW_GROUPS) / 2;

  logic      rise1, step, load;
  scan_cfg_t eff_cfg;

  cs_phase_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase1 (phase1),
    .phase2 (phase2),
    .rise1  (rise1),
    .step   (step)
  );

  assign load = rise1 & start;

  cs_line_cfg #(
    .NUM_GROUPS    (NUM_GROUPS),
    .BORDER_GROUPS (BORDER_GROUPS)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .dir_in  (dir_right),
    .wide_in (wide_n),
    .eff_cfg (eff_cfg),
    .black_o (grp_black)
  );

  cs_token_chain #(
    .NUM_GROUPS    (NUM_GROUPS),
    .BORDER_GROUPS (BORDER_GROUPS)
  ) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .cfg   (eff_cfg),
    .tok   (grp_en)
  );
endmodule

// File: rtl/col_scan_chk.sv
module col_scan_chk #(
  parameter int NUM_GROUPS    = 86,
  parameter int BORDER_GROUPS = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  phase1,
  input logic                  phase2,
  input logic                  start,
  input logic                  dir_right,
  input logic                  wide_n,
  input logic [NUM_GROUPS-1:0] grp_en,
  input logic [NUM_GROUPS-1:0] grp_black
);
  assert_onehot_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_en));

  assert_black_never_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_en & grp_black) == '0);

  assert_hold_without_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(phase1) || $rose(phase2)) |=> $stable(grp_en));

  assert_first_right_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phase1) && start && dir_right && wide_n) |=> grp_en[0]);

  assert_first_left_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phase1) && start && !dir_right && wide_n) |=> grp_en[NUM_GROUPS-1]);

  assert_first_right_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phase1) && start && dir_right && !wide_n) |=> grp_en[BORDER_GROUPS]);
endmodule

bind col_scan_top col_scan_chk #(
  .NUM_GROUPS    (NUM_GROUPS),
  .BORDER_GROUPS (BORDER_GROUPS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase1    (phase1),
  .phase2    (phase2),
  .start     (start),
  .dir_right (dir_right),
  .wide_n    (wide_n),
  .grp_en    (grp_en),
  .grp_black (grp_black)
);

// File: tb/col_scan_top_tb_top.sv
`timescale 1ns/1ps
module col_scan_top_tb_top;
  localparam int NG = 1032 / 12;         // 86 groups
  localparam int BG = (NG - 960 / 12) / 2; // 3 border groups per side

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase1 = 1'b0;
  logic phase2 = 1'b1;
  logic start = 1'b0;
  logic dir_right = 1'b1;
  logic wide_n = 1'b1;
  logic [NG-1:0] grp_en, grp_black;

  int n_tests = 0;
  int n_fail = 0;

  // Reference state: latched config and step number within the line
  logic m_right = 1'b1;
  logic m_wide = 1'b1;
  int   m_k = 0;

  always #10 clk = ~clk;

  col_scan_top dut_i (
    .clk(clk), .rst_n(rst_n), .phase1(phase1), .phase2(phase2),
    .start(start), .dir_right(dir_right), .wide_n(wide_n),
    .grp_en(grp_en), .grp_black(grp_black)
  );

  function automatic logic [NG-1:0] exp_en_f(logic r, logic w, int k);
    logic [NG-1:0] v;
    int lo, hi, cnt;
    v = '0;
    lo = w ? 0 : BG;
    hi = w ? NG-1 : NG-1-BG;
    cnt = hi - lo + 1;
    if (k >= 1 && k <= cnt) v[r ? lo + k - 1 : hi - (k - 1)] = 1'b1;
    return v;
  endfunction

  function automatic logic [NG-1:0] exp_black_f(logic w);
    logic [NG-1:0] v;
    v = '0;
    if (!w) for (int i = 0; i < NG; i++) v[i] = (i < BG) || (i >= NG - BG);
    return v;
  endfunction

  task automatic check(string tag);
    logic [NG-1:0] ee, eb;
    ee = exp_en_f(m_right, m_wide, m_k);
    eb = exp_black_f(m_wide);
    n_tests++;
    if (grp_en !== ee || grp_black !== eb) begin
      n_fail++;
      $display("FAIL %s step=%0d en=%h exp_en=%h black=%h exp_black=%h",
               tag, m_k, grp_en, ee, grp_black, eb);
    end
  endtask

  // One phase toggle = one scan step; then a hold cycle with no edge
  task automatic do_step(logic s, string tag);
    logic rising1;
    @(negedge clk);
    rising1 = !phase1;
    start = s;
    phase1 = ~phase1;
    phase2 = ~phase2;
    if (rising1 && s) begin
      m_right = dir_right;
      m_wide = wide_n;
      m_k = 1;
    end else if (m_k > 0 && m_k <= NG) begin
      m_k++;
    end
    @(posedge clk); #2;
    check(tag);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); #2;
    check({tag, " hold R9"});
  endtask

  task automatic align_phase1;
    if (phase1) do_step(1'b0, "align R4");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check("reset R1");
    repeat (2) @(posedge clk); #2;
    check("reset idle R1");

    // Start held with no phase edge: ignored (R2)
    @(negedge clk); start = 1'b1;
    @(posedge clk); #2;
    check("start without edge R2");
    @(negedge clk); start = 1'b0;

    // Full sweep of four configurations (R2 R4 R5 R6 R7)
    for (int c = 0; c < 4; c++) begin
      align_phase1();
      dir_right = c[0];
      wide_n = c[1];
      do_step(1'b1, "line start R2");
      for (int s = 0; s < NG + 1; s++)
        do_step(1'b0, wide_n ? "full scan R4 R5" : "narrow scan R4 R6 R7");
    end

    // Start on a phase 2 rise is ignored (R2)
    align_phase1();
    do_step(1'b0, "pre R2");
    do_step(1'b1, "phase2 start ignored R2");

    // Mid-line config change has no effect (R8)
    align_phase1();
    dir_right = 1'b1; wide_n = 1'b1;
    do_step(1'b1, "R8 start");
    for (int s = 0; s < 10; s++) do_step(1'b0, "R8 before change");
    dir_right = 1'b0; wide_n = 1'b0;
    for (int s = 0; s < 30; s++) do_step(1'b0, "R8 after change");

    // Restart mid-line with new config, load wins over shift (R10)
    align_phase1();
    do_step(1'b1, "R10 restart narrow left");
    for (int s = 0; s < 20; s++) do_step(1'b0, "R10 run");
    align_phase1();
    dir_right = 1'b1; wide_n = 1'b1;
    do_step(1'b1, "R10 restart full right");
    for (int s = 0; s < 5; s++) do_step(1'b0, "R10 after");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule